// File: doc/BRIEF.md
# Seconds Timer with Alarm

This block is a free-running seconds timer meant for an always-powered domain. A programmable divider turns a slow reference clock into a periodic tick. With the divider set to the reference frequency, for example 32768 for a 32.768 kHz crystal, the tick comes once per second. Each tick advances a 32-bit up-counter. Software can read the counter and restart it from zero, but it cannot load a value into it. Time of day is kept outside the block as an offset that software adds to the count.

A 32-bit alarm value is compared with the counter on every tick. Two sticky event flags, one for alarm and one for increment, collect in a status word that clears when it is read. One level-sensitive interrupt line is raised when a set flag has its enable bit set. All access is through a small register bus with separate read and write strobes. Read data comes back one cycle after the read strobe.

Top module: `sec_timer`

## Requirements
- R1: After reset the control word reads 0 (divider 0, both interrupt enables off), the alarm reads 0xFFFFFFFF, the count reads 0, the status reads 0 and `irq` is low.
- R2: The control word at address 0x0 holds the divider in bits [15:0], the alarm interrupt enable in bit 16 and the increment interrupt enable in bit 17. Bit 18 is a restart command that always reads back 0, and every other bit reads 0.
- R3: With divider value P in 1..65535 the count advances once every P clock cycles. A divider of 0 divides by 65536. The count changes at no other time.
- R4: The count is read at address 0x8 and is read-only: a write to 0x8 changes nothing.
- R5: A control write with bit 18 set clears both the count and the divider phase on that clock edge. The written divider and enables take effect on the same edge. A tick that falls on that edge is discarded.
- R6: The alarm value at address 0x4 is a 32-bit read/write register.
- R7: Status bit 1 sets on every count advance. Status bit 0 sets on the advance whose new count equals the alarm value, and it never sets while the alarm value is 0xFFFFFFFF.
- R8: A read of the status word at address 0xC returns the flags and clears them. An event that occurs in the same cycle as that read leaves its flag set.
- R9: `irq` is a registered output. It is high in the cycle after (status bit 0 AND enable bit 16) OR (status bit 1 AND enable bit 17) holds, and low otherwise.
- R10: `bus_rdata` is registered. It updates on the edge where `bus_rd` is sampled high and keeps its value otherwise. Addresses other than 0x0, 0x4, 0x8 and 0xC read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register accessed |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a read of 0xC clears the status flags |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check the following on every cycle:
- the count holds between ticks and steps by exactly one on a tick;
- a restart clears the count, and a write to the count address leaves it unchanged;
- a tick always raises the increment flag, and the all-ones alarm never raises the alarm flag;
- a status read clears the flags;
- `irq` follows the enabled flags one cycle later.

Only the bench scenarios can show the following:
- the real tick spacing for several divider values, including the divide-by-65536 case;
- the alarm landing on the exact count;
- a flag that survives a read because an event arrives in the same cycle;
- the values each address returns.

These scenarios are compared against a behavioural model on every clock.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int unsigned DIV_W       = 16;
  localparam int unsigned OFS_CTRL    = 'h0;
  localparam int unsigned OFS_ALARM   = 'h4;
  localparam int unsigned OFS_COUNT   = 'h8;
  localparam int unsigned OFS_STAT    = 'hC;
  localparam int unsigned BIT_ALM_EN  = 16;
  localparam int unsigned BIT_INC_EN  = 17;
  localparam int unsigned BIT_RESTART = 18;
  localparam int unsigned FLG_ALM     = 0;
  localparam int unsigned FLG_INC     = 1;
  localparam int unsigned NUM_FLAGS   = 2;
endpackage

// File: rtl/sst_prescaler.sv
module sst_prescaler #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic [W-1:0] div,
  output logic         tick
);
  logic [W-1:0] phase_q;

  // A divider of 0 wraps div-1 to all ones, giving 2**W cycles per tick.
  assign tick = (phase_q == (div - W'(1)));

  always_ff @(posedge clk) begin
    if (rst || restart) phase_q <= '0;
    else if (tick)      phase_q <= '0;
    else                phase_q <= phase_q + W'(1);
  end
endmodule

// File: rtl/sst_counter.sv
module sst_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         tick,
  input  logic [W-1:0] alarm,
  output logic [W-1:0] count,
  output logic         inc_ev,
  output logic         alm_ev
);
  logic [W-1:0] next_cnt;

  assign next_cnt = count + W'(1);
  assign inc_ev   = tick && !restart;
  assign alm_ev   = inc_ev && (next_cnt == alarm) && (alarm != '1);

  always_ff @(posedge clk) begin
    if (rst || restart) count <= '0;
    else if (tick)      count <= next_cnt;
  end
endmodule

// File: rtl/sst_status.sv
module sst_status #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_clr,
  input  logic [N-1:0] events,
  input  logic [N-1:0] enables,
  output logic [N-1:0] flags,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= (rd_clr ? '0 : flags) | events;
      irq   <= |(flags & enables);
    end
  end
endmodule

// File: rtl/sec_timer.sv
module sec_timer
  import sst_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [DIV_W-1:0]     div_q;
  logic                 alm_en_q, inc_en_q;
  logic [DATA_W-1:0]    alarm_q;
  logic [DATA_W-1:0]    count;
  logic                 tick, inc_ev, alm_ev, restart, rd_clr;
  logic [NUM_FLAGS-1:0] flags, events, enables;
  logic                 sel_ctrl, sel_alarm, sel_count, sel_stat;
  logic [DATA_W-1:0]    rd_ctrl, rd_stat, rd_mux;

  assign sel_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
  assign sel_alarm = (bus_addr == ADDR_W'(OFS_ALARM));
  assign sel_count = (bus_addr == ADDR_W'(OFS_COUNT));
  assign sel_stat  = (bus_addr == ADDR_W'(OFS_STAT));
  assign restart   = bus_wr && sel_ctrl && bus_wdata[BIT_RESTART];
  assign rd_clr    = bus_rd && sel_stat;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q    <= '0;
      alm_en_q <= 1'b0;
      inc_en_q <= 1'b0;
      alarm_q  <= '1;
    end else if (bus_wr) begin
      if (sel_ctrl) begin
        div_q    <= bus_wdata[DIV_W-1:0];
        alm_en_q <= bus_wdata[BIT_ALM_EN];
        inc_en_q <= bus_wdata[BIT_INC_EN];
      end
      if (sel_alarm) alarm_q <= bus_wdata;
    end
  end

  sst_prescaler #(.W(DIV_W)) u_presc (
    .clk(clk), .rst(rst), .restart(restart), .div(div_q), .tick(tick)
  );

  sst_counter #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .restart(restart), .tick(tick), .alarm(alarm_q),
    .count(count), .inc_ev(inc_ev), .alm_ev(alm_ev)
  );

  always_comb begin
    events            = '0;
    events[FLG_ALM]   = alm_ev;
    events[FLG_INC]   = inc_ev;
    enables           = '0;
    enables[FLG_ALM]  = alm_en_q;
    enables[FLG_INC]  = inc_en_q;
  end

  sst_status #(.N(NUM_FLAGS)) u_stat (
    .clk(clk), .rst(rst), .rd_clr(rd_clr), .events(events),
    .enables(enables), .flags(flags), .irq(irq)
  );

  always_comb begin
    rd_ctrl              = '0;
    rd_ctrl[DIV_W-1:0]   = div_q;
    rd_ctrl[BIT_ALM_EN]  = alm_en_q;
    rd_ctrl[BIT_INC_EN]  = inc_en_q;
    rd_stat              = '0;
    rd_stat[NUM_FLAGS-1:0] = flags;
    if (sel_ctrl)       rd_mux = rd_ctrl;
    else if (sel_alarm) rd_mux = alarm_q;
    else if (sel_count) rd_mux = count;
    else if (sel_stat)  rd_mux = rd_stat;
    else                rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/chk_sec_timer.sv
module chk_sec_timer #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic              tick,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] alarm,
  input logic [1:0]        flags,
  input logic [1:0]        en
);
  logic rst_cmd, alarm_wr;
  assign rst_cmd  = bus_wr && (bus_addr == ADDR_W'(0)) && bus_wdata[18];
  assign alarm_wr = bus_wr && (bus_addr == ADDR_W'(4));

  AST_CTRL_RESTART_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rd && (bus_addr == ADDR_W'(0)) |=> !bus_rdata[18]); // R2
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick && !rst_cmd |=> $stable(cnt)); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    tick && !rst_cmd |=> cnt == $past(cnt) + DATA_W'(1)); // R3
  AST_COUNT_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
    bus_wr && (bus_addr == ADDR_W'(8)) && !tick && !rst_cmd |=> $stable(cnt)); // R4
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
    rst_cmd |=> cnt == '0); // R5
  AST_TICK_SETS_INC: assert property (@(posedge clk) disable iff (rst)
    tick && !rst_cmd |=> flags[1]); // R7
  AST_NO_ALARM_WHEN_UNUSED: assert property (@(posedge clk) disable iff (rst)
    (alarm == '1) && !alarm_wr && !flags[0] |=> !flags[0]); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    bus_rd && (bus_addr == ADDR_W'(12)) && !tick |=> flags == 2'b00); // R8
  AST_IRQ_HIGH: assert property (@(posedge clk) disable iff (rst)
    |(flags & en) |=> irq); // R9
  AST_IRQ_LOW: assert property (@(posedge clk) disable iff (rst)
    !(|(flags & en)) |=> !irq); // R9
endmodule

bind sec_timer chk_sec_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .tick(tick),
  .cnt(count), .alarm(alarm_q), .flags(flags), .en({inc_en_q, alm_en_q})
);

// File: tb/tb_sec_timer.sv
module tb_sec_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int checks = 0, errors = 0;
  logic [31:0] d;

  always #5 clk = ~clk;

  sec_timer dut (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  // behavioural reference
  int          m_phase;
  int          m_div;
  bit          m_aen, m_ien;
  logic [31:0] m_cnt, m_alarm, m_rdata;
  bit          m_falm, m_finc, m_irq;

  always @(posedge clk) begin
    int period;
    bit tk, rs, ev_inc, ev_alm;
    logic [31:0] rv;
    if (rst) begin
      m_phase = 0; m_div = 0; m_aen = 0; m_ien = 0; m_cnt = 0;
      m_alarm = 32'hFFFF_FFFF; m_rdata = 0; m_falm = 0; m_finc = 0; m_irq = 0;
    end else begin
      period = (m_div == 0) ? 65536 : m_div;
      tk = (m_phase == period - 1);
      rs = bus_wr && bus_addr == 4'h0 && bus_wdata[18];
      ev_inc = tk && !rs;
      ev_alm = ev_inc && (m_cnt + 1 == m_alarm) && (m_alarm != 32'hFFFF_FFFF);
      case (bus_addr)
        4'h0: rv = {14'd0, m_ien, m_aen, m_div[15:0]};
        4'h4: rv = m_alarm;
        4'h8: rv = m_cnt;
        4'hC: rv = {30'd0, m_finc, m_falm};
        default: rv = 0;
      endcase
      if (bus_rd) m_rdata = rv;
      m_irq = (m_falm && m_aen) || (m_finc && m_ien);
      if (bus_rd && bus_addr == 4'hC) begin m_falm = 0; m_finc = 0; end
      if (ev_inc) m_finc = 1;
      if (ev_alm) m_falm = 1;
      if (rs) begin m_cnt = 0; m_phase = 0; end
      else if (tk) begin m_cnt = m_cnt + 1; m_phase = 0; end
      else m_phase = (m_phase + 1) % 65536;
      if (bus_wr && bus_addr == 4'h0) begin
        m_div = int'(bus_wdata[15:0]); m_aen = bus_wdata[16]; m_ien = bus_wdata[17];
      end
      if (bus_wr && bus_addr == 4'h4) m_alarm = bus_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // compare the outputs against the reference on every clock (R9, R10)
  always @(negedge clk) begin
    if (!rst) begin
      chk("R10 rdata vs model", bus_rdata, m_rdata);
      chk("R9 irq vs model", {31'd0, irq}, {31'd0, m_irq});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3); rst = 1'b0;
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    rd(4'h0, d); chk("R1 ctrl reset", d, 32'h0);
    rd(4'h4, d); chk("R1 alarm reset", d, 32'hFFFF_FFFF);
    rd(4'h8, d); chk("R1 count reset", d, 32'h0);
    rd(4'hC, d); chk("R1 status reset", d, 32'h0);

    // R4: the count is frozen under divide-by-65536 right after a restart
    wr(4'h0, 32'h0004_0000);
    wr(4'h8, 32'hDEAD_BEEF);
    rd(4'h8, d); chk("R4 count not writable", d, 32'h0);

    // R3 / R5: divider 4, restart; read after wait w=40 -> floor(41/4)=10
    wr(4'h0, 32'h0004_0004);
    idle(40);
    rd(4'h8, d); chk("R3 divide by 4", d, 32'd10);
    rd(4'h0, d); chk("R2 ctrl readback, restart reads 0", d, 32'h0000_0004);

    // R5: divider 1, restart then immediate read -> one tick only
    wr(4'h0, 32'h0004_0001);
    rd(4'h8, d); chk("R5 restart discards concurrent tick", d, 32'd1);

    // R8: events every cycle, flag survives a clearing read
    rd(4'hC, d); chk("R8 status returns inc flag", d, 32'h2);
    rd(4'hC, d); chk("R8 same-cycle event keeps flag", d, 32'h2);

    // R6 / R7 / R9: alarm at count 3 with divider 2
    wr(4'h4, 32'd3);
    rd(4'h4, d); chk("R6 alarm readback", d, 32'd3);
    wr(4'h0, 32'h0005_0002);
    rd(4'hC, d);
    idle(10);
    chk("R9 irq on alarm", {31'd0, irq}, 32'd1);
    rd(4'hC, d); chk("R7 alarm and inc flags", d, 32'h3);
    idle(1);
    chk("R9 irq drops after clear", {31'd0, irq}, 32'd0);
    rd(4'hC, d); chk("R8 alarm flag cleared", d & 32'h1, 32'h0);

    // R7: all-ones alarm never fires
    wr(4'h4, 32'hFFFF_FFFF);
    wr(4'h0, 32'h0005_0001);
    rd(4'hC, d);
    idle(20);
    rd(4'hC, d); chk("R7 unused alarm silent", d, 32'h2);

    // R9: increment interrupt enable
    wr(4'h0, 32'h0006_0003);
    idle(8);
    chk("R9 irq on increment", {31'd0, irq}, 32'd1);

    // R10: unmapped address and hold
    rd(4'hE, d); chk("R10 unmapped reads 0", d, 32'h0);
    idle(3);
    chk("R10 rdata holds", bus_rdata, 32'h0);

    // R3: divider 0 -> 65536; wait w=65535 -> exactly one tick
    wr(4'h0, 32'h0004_0000);
    rd(4'hC, d);
    idle(65533);
    rd(4'h8, d); chk("R3 divide by 65536", d, 32'd1);
    rd(4'hC, d); chk("R7 inc flag after long period", d, 32'h2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule